// File: doc/BRIEF.md
# Multi-Flag Synchronous FIFO with Read Rewind

This block is a single-clock first-in first-out buffer of 2048 words of 9 bits. A write enable and a read enable are sampled on each rising clock edge. Each strobe is acted on only if the FIFO can accept it: a write needs free space and a read needs stored data. Read data is registered and appears after the edge that accepted the read.

Occupancy is reported on six active-low status outputs, arranged from the empty side to the full side. They are empty, at-most-one-word, the two-sided almost-empty/almost-full indication, more-than-half, one-short-of-full and full. Every flag is registered from the occupancy count the FIFO will hold after the current edge, so all flags change on the edge that changes the count. A rewind input moves the read position back to the first location so that the words already read can be read again. The contents of the storage are left as they are.

Top module: `mff_fifo`

## Requirements
- R1: A synchronous active-high `rst` clears the write position, the read position, the count and `rd_data`. On the edge after reset the flags are `empty_n`=0, `empty1_n`=0, `almost_n`=0, `half_n`=1, `fullm1_n`=1 and `full_n`=1.
- R2: A write with `wr_en`=1 is stored only while `full_n` is 1. While `full_n` is 0 it is dropped, and the stored data and the count do not change.
- R3: `full_n` is 0 exactly when the count equals DEPTH.
- R4: A read with `rd_en`=1 is accepted only while `empty_n` is 1. After the accepting edge, `rd_data` shows the oldest unread word, in the order the words were written. A read while `empty_n` is 0 is dropped and `rd_data` holds its value.
- R5: `empty_n` is 0 exactly when the count is 0.
- R6: `empty1_n` is 0 exactly when the count is 0 or 1.
- R7: `fullm1_n` is 0 exactly when the count is DEPTH-1 or more.
- R8: `half_n` is 0 exactly when the count is greater than DEPTH/2.
- R9: `almost_n` is 0 when the count is at most DEPTH/8 or at least DEPTH-DEPTH/8, and 1 strictly between those bounds.
- R10: A read and a write accepted on the same edge both take effect and leave the count unchanged.
- R11: When `retx`=1 on an edge, the read position returns to location 0 and the count is reloaded with the write position. Any read or write on that edge is dropped, and the stored data is not changed.
- R12: All six flags reflect the new count on the same edge that accepts the write, read or rewind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to write |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Rewind the read position to location 0 |
| rd_data | output | 9 | Registered read word |
| empty_n | output | 1 | Low when empty |
| empty1_n | output | 1 | Low when holding zero or one word |
| almost_n | output | 1 | Low when at most 1/8 full or at least 7/8 full |
| half_n | output | 1 | Low when more than half full |
| fullm1_n | output | 1 | Low when at most one word from full |
| full_n | output | 1 | Low when full |

## Verification
A short table of mixed operations from reset covers the following cases: single writes, single reads, a read and a write on the same edge, a read on an empty FIFO, and a read with a write on an empty FIFO. Together they separate a correct count update from one that drops or double-counts, and they show that a blocked read leaves `rd_data` alone. A complete fill followed by a complete drain steps the count through every flag threshold from both sides. This catches off-by-one errors at DEPTH/8, DEPTH/2, 7/8 and DEPTH-1. A write attempted while full is followed by a drain check that the extra word never appears. A partial fill, partial read and rewind check that data is replayed from location 0 with the reloaded count, and that a write on the rewind edge is dropped.

// File: rtl/mff_pkg.sv
package mff_pkg;

    typedef struct packed {
        logic empty_n;
        logic empty1_n;
        logic almost_n;
        logic half_n;
        logic fullm1_n;
        logic full_n;
    } mff_flags_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_BOTH = 2'b11
    } mff_op_e;

    localparam mff_flags_t FLAGS_AT_RESET = '{
        empty_n: 1'b0, empty1_n: 1'b0, almost_n: 1'b0,
        half_n: 1'b1, fullm1_n: 1'b1, full_n: 1'b1
    };

    // Occupancy to active-low flag set; thresholds scale with depth.
    function automatic mff_flags_t mff_decode(input logic [31:0] cnt,
                                              input logic [31:0] depth);
        mff_flags_t f;
        logic [31:0] eighth;
        eighth     = depth >> 3;
        f.empty_n  = (cnt != 32'd0);
        f.empty1_n = (cnt > 32'd1);
        f.almost_n = !((cnt <= eighth) || (cnt >= depth - eighth));
        f.half_n   = !(cnt > (depth >> 1));
        f.fullm1_n = !(cnt >= depth - 32'd1);
        f.full_n   = (cnt != depth);
        return f;
    endfunction

endpackage

// File: rtl/mff_mem.sv
module mff_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/mff_ctrl.sv
module mff_ctrl
    import mff_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          retx,
    input  logic          full_n,
    input  logic          empty_n,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] cnt_nxt
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [CW-1:0] cnt;
    mff_op_e       op;

    assign wr_go = wr_req && full_n  && !retx;
    assign rd_go = rd_req && empty_n && !retx;
    assign op    = mff_op_e'({wr_go, rd_go});

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        unique case (op)
            OP_WR:   cnt_nxt = cnt + 1'b1;
            OP_RD:   cnt_nxt = cnt - 1'b1;
            default: cnt_nxt = cnt;
        endcase
        if (retx) cnt_nxt = CW'(wr_ptr);
        if (rst)  cnt_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (wr_go) wr_ptr <= bump(wr_ptr);
            if (retx)       rd_ptr <= '0;
            else if (rd_go) rd_ptr <= bump(rd_ptr);
        end
    end
endmodule

// File: rtl/mff_flags.sv
module mff_flags
    import mff_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_nxt,
    output mff_flags_t    flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= FLAGS_AT_RESET;
        else     flags <= mff_decode(32'(cnt_nxt), 32'(DEPTH));
    end
endmodule

// File: rtl/mff_fifo.sv
module mff_fifo
    import mff_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             retx,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    output logic             empty1_n,
    output logic             almost_n,
    output logic             half_n,
    output logic             fullm1_n,
    output logic             full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    mff_flags_t    flags;
    logic          wr_go, rd_go;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_nxt;

    mff_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_en), .retx(retx),
        .full_n(flags.full_n), .empty_n(flags.empty_n),
        .wr_go(wr_go), .rd_go(rd_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .cnt_nxt(cnt_nxt)
    );

    mff_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst(rst), .we(wr_go), .waddr(wr_ptr), .wdata(wr_data),
        .re(rd_go), .raddr(rd_ptr), .rdata(rd_data)
    );

    mff_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .flags(flags)
    );

    assign empty_n  = flags.empty_n;
    assign empty1_n = flags.empty1_n;
    assign almost_n = flags.almost_n;
    assign half_n   = flags.half_n;
    assign fullm1_n = flags.fullm1_n;
    assign full_n   = flags.full_n;
endmodule

// File: rtl/mff_fifo_chk.sv
module mff_fifo_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             retx,
    input logic [WIDTH-1:0] rd_data,
    input logic             empty_n,
    input logic             empty1_n,
    input logic             almost_n,
    input logic             half_n,
    input logic             fullm1_n,
    input logic             full_n
);
    assert_reset_flags_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({empty_n, empty1_n, almost_n, half_n, fullm1_n, full_n} == 6'b000111));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_en && !rd_en && !retx) |=> !full_n);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en && !wr_en && !retx) |=> (!empty_n && $stable(rd_data)));

    assert_full_implies_fullm1_R7: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> (!fullm1_n && !half_n && !almost_n));

    assert_empty_implies_empty1_R6: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> (!empty1_n && half_n && !almost_n));

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd_en && !retx) |=> $stable({empty_n, empty1_n, almost_n, half_n, fullm1_n, full_n}));
endmodule

bind mff_fifo mff_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .retx(retx),
    .rd_data(rd_data), .empty_n(empty_n), .empty1_n(empty1_n),
    .almost_n(almost_n), .half_n(half_n), .fullm1_n(fullm1_n), .full_n(full_n)
);

// File: tb/mff_fifo_tb.sv
module mff_fifo_tb;
    localparam int W = 9;
    localparam int D = 2048;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic empty_n, empty1_n, almost_n, half_n, fullm1_n, full_n;

    int errors = 0;
    int checks = 0;

    mff_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .retx(retx), .rd_data(rd_data), .empty_n(empty_n), .empty1_n(empty1_n),
        .almost_n(almost_n), .half_n(half_n), .fullm1_n(fullm1_n), .full_n(full_n)
    );

    always #4 clk = ~clk;

    // {wr, rd, din[8:0], exp_dout[8:0], exp flags {e, e1, al, hf, fm1, f}}
    localparam logic [25:0] VEC [8] = '{
        {1'b1, 1'b0, 9'h101, 9'h000, 6'b100111},
        {1'b1, 1'b0, 9'h0A5, 9'h000, 6'b110111},
        {1'b0, 1'b1, 9'h000, 9'h101, 6'b100111},
        {1'b1, 1'b1, 9'h1FF, 9'h0A5, 6'b100111},
        {1'b0, 1'b1, 9'h000, 9'h1FF, 6'b000111},
        {1'b0, 1'b1, 9'h000, 9'h1FF, 6'b000111},
        {1'b1, 1'b1, 9'h033, 9'h1FF, 6'b100111},
        {1'b0, 1'b1, 9'h000, 9'h033, 6'b000111}
    };

    // Reference model built from the requirements
    logic [W-1:0] mmem [D];
    int mwp, mrp, mcnt;
    logic [W-1:0] mdout;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic rt, input logic [W-1:0] d);
        wr_en = w; rd_en = r; retx = rt; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; retx = 1'b0;
    endtask

    task automatic model(input logic w, input logic r, input logic rt, input logic [W-1:0] d);
        bit wok, rok;
        if (rt) begin
            mrp = 0;
            mcnt = mwp;
        end else begin
            wok = w && (mcnt != D);
            rok = r && (mcnt != 0);
            if (rok) begin
                mdout = mmem[mrp];
                mrp = (mrp + 1) % D;
            end
            if (wok) begin
                mmem[mwp] = d;
                mwp = (mwp + 1) % D;
            end
            mcnt = mcnt + int'(wok) - int'(rok);
        end
    endtask

    task automatic check_state(input string ctx);
        check(empty_n == (mcnt != 0), {"R5 empty_n ", ctx}, empty_n, mcnt != 0);
        check(empty1_n == (mcnt > 1), {"R6 empty1_n ", ctx}, empty1_n, mcnt > 1);
        check(almost_n == !((mcnt <= D/8) || (mcnt >= D - D/8)), {"R9 almost_n ", ctx},
              almost_n, !((mcnt <= D/8) || (mcnt >= D - D/8)));
        check(half_n == !(mcnt > D/2), {"R8 half_n ", ctx}, half_n, !(mcnt > D/2));
        check(fullm1_n == !(mcnt >= D - 1), {"R7 fullm1_n ", ctx}, fullm1_n, !(mcnt >= D - 1));
        check(full_n == (mcnt != D), {"R3 full_n ", ctx}, full_n, mcnt != D);
        check(rd_data == mdout, {"R4 rd_data ", ctx}, rd_data, mdout);
    endtask

    task automatic op(input logic w, input logic r, input logic rt, input logic [W-1:0] d,
                      input string ctx);
        drive(w, r, rt, d);
        model(w, r, rt, d);
        check_state(ctx);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mwp = 0; mrp = 0; mcnt = 0; mdout = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check({empty_n, empty1_n, almost_n, half_n, fullm1_n, full_n} == 6'b000111,
              "R1 reset flags", {empty_n, empty1_n, almost_n, half_n, fullm1_n, full_n}, 6'b000111);
        check(rd_data == '0, "R1 reset rd_data", rd_data, 0);

        // Table walk: R2 R4 R10 R12
        for (int i = 0; i < 8; i++) begin
            logic [25:0] v;
            v = VEC[i];
            drive(v[25], v[24], 1'b0, v[23:15]);
            check({empty_n, empty1_n, almost_n, half_n, fullm1_n, full_n} == v[5:0],
                  $sformatf("R12 R10 table flags %0d", i),
                  {empty_n, empty1_n, almost_n, half_n, fullm1_n, full_n}, v[5:0]);
            check(rd_data == v[14:6], $sformatf("R4 table rd_data %0d", i), rd_data, v[14:6]);
        end

        // Fill completely, then attempt one more write (R2, R3)
        do_reset();
        check_state("R1 after second reset");
        for (int k = 0; k < D; k++) op(1'b1, 1'b0, 1'b0, W'(k * 37 + 5), "fill");
        op(1'b1, 1'b0, 1'b0, 9'h1AA, "R2 write while full");
        // Drain: data order and that the dropped word never shows (R2, R4)
        for (int k = 0; k < D; k++) op(1'b0, 1'b1, 1'b0, '0, "drain");
        op(1'b0, 1'b1, 1'b0, '0, "R4 read while empty");

        // Rewind: R11
        do_reset();
        for (int k = 0; k < 10; k++) op(1'b1, 1'b0, 1'b0, W'(k + 100), "R11 pre-fill");
        for (int k = 0; k < 4; k++)  op(1'b0, 1'b1, 1'b0, '0, "R11 pre-read");
        op(1'b1, 1'b1, 1'b1, 9'h0EE, "R11 rewind with dropped write");
        check(empty1_n == 1'b1 && empty_n == 1'b1, "R11 count after rewind", empty1_n, 1);
        op(1'b0, 1'b1, 1'b0, '0, "R11 replay first");
        check(rd_data == 9'd100, "R11 replayed word", rd_data, 100);
        for (int k = 1; k < 10; k++) op(1'b0, 1'b1, 1'b0, '0, "R11 replay rest");
        check(empty_n == 1'b0, "R11 empty after replay", empty_n, 0);

        finish_run();
    end
endmodule